// File: doc/BRIEF.md
# Serial Receiver with Status Flags

This block receives asynchronous serial frames on a single input line and presents each received byte to the bus side together with four status flags: overrun, framing error, parity error and buffer full. The line is oversampled at sixteen ticks per bit. The ticks come from an internal divider whose reload value is an input. A mode word selects one or two stop bits, turns the parity bit on or off, and chooses odd or even parity.

The received byte leaves through a valid/ready pair. `data_valid` is the buffer-full flag. A transfer happens on a clock edge where `data_valid` and `data_ready` are both high, and that transfer empties the buffer. The serial line cannot be stalled, so back-pressure is never applied to the sender. A byte that the consumer has not taken is overwritten by the next frame, and the overrun flag records the loss.

The error flags stay set until a status read. A status read is the run of cycles during which `stat_rd` is high. A frame that completes inside that run is held back and applied in the first cycle after it. A receiver-initialize pulse returns the receiver to idle and clears all flags.

Top module: `uart_rx_status`

## Requirements
- R1: When a frame completes while the previous byte is still valid and is not being taken in that cycle, `ovr_err` sets and `data_out` takes the new byte.
- R2: When a frame completes while `frm_err` or `par_err` is still set from an earlier frame, `ovr_err` sets, even if that earlier byte was never marked valid.
- R3: `ovr_err`, `frm_err` and `par_err` all read 0 in the cycle after any cycle with `stat_rd` high.
- R4: `frm_err` sets when a stop bit is sampled low. With two stop bits (mode bit 3 = 1), it sets if either stop bit is low.
- R5: When mode bit 5 = 1, one parity bit follows the data bits. Mode bit 4 = 1 asks for an odd count of ones over the data and parity bits, and 0 asks for an even count. `par_err` sets on a mismatch. When mode bit 5 = 0, no parity bit is expected and `par_err` never sets.
- R6: `data_valid` rises when the last stop bit of an error-free frame has been sampled. A frame with a framing or parity error does not raise it.
- R7: `data_valid` falls after a cycle in which `data_valid` and `data_ready` are both high.
- R8: A frame that completes while `stat_rd` is high changes neither `data_valid`, `data_out` nor the flags until the first cycle with `stat_rd` low. Its results are applied then.
- R9: Data bits arrive LSB first after the start bit. `data_out` changes only when a frame completes.
- R10: A low pulse on `rxd` that has ended by the middle of the start bit is not taken as a start bit. It produces no byte and no flag.
- R11: The receiver takes one sample tick every `baud_div`+1 clocks and sixteen ticks per bit, so one bit lasts 16×(`baud_div`+1) clocks.
- R12: A `rx_init` pulse clears all four flags, drops any frame in progress or held back, and returns the receiver to waiting for an idle-high line.
- R13: After reset, `data_valid`, `ovr_err`, `frm_err` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Tick divider reload; one tick every baud_div+1 clocks |
| rxd | input | 1 | Serial input line, idle high |
| mode | input | 8 | Bit 3: two stop bits, bit 4: odd parity, bit 5: parity enable |
| stat_rd | input | 1 | High for the cycles of a status read; clears error flags |
| rx_init | input | 1 | Receiver initialize pulse |
| data_valid | output | 1 | Buffer full: received byte available |
| data_ready | input | 1 | Consumer takes the byte when high with data_valid |
| data_out | output | 8 | Received byte |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |

## Verification
The hardest case to reach is a frame that ends while a status read is still in progress, because the end of a frame falls somewhere inside the last stop bit. The bench raises `stat_rd` when it starts driving the last stop bit and holds it for the whole of that bit. At the end of the bit it checks that the buffer is still empty and `data_out` is unchanged. It then drops the read and checks that the held-back byte appears. The second overrun cause is reached by leaving a framing error unread and then sending a clean frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MODE_TWO_STOP = 3;
  localparam int MODE_ODD      = 4;
  localparam int MODE_PAR_EN   = 5;

  typedef struct packed {
    logic [7:0] data;
    logic       frm;
    logic       par;
  } rx_frame_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_t;
endpackage

// File: rtl/rx_baud_tick.sv
module rx_baud_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import uart_rx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      two_stop,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      init,
  output logic      done,
  output rx_frame_t frame
);
  localparam int CW  = $clog2(OS);
  localparam int MID = OS / 2 - 1;

  rx_state_t  state;
  logic [CW-1:0] os_cnt;
  logic [2:0] bit_idx;
  logic [7:0] shreg;
  logic       par_acc, perr_q, bad_stop, line_q;
  logic       two_q, pen_q, odd_q;
  logic       bit_end, fin;

  always_comb begin
    bit_end = tick && (os_cnt == CW'(OS - 1));
    fin     = bit_end && ((state == S_STOP2) || (state == S_STOP1 && !two_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; os_cnt <= '0; bit_idx <= '0; shreg <= '0;
      par_acc <= 1'b0; perr_q <= 1'b0; bad_stop <= 1'b0; line_q <= 1'b0;
      two_q <= 1'b0; pen_q <= 1'b0; odd_q <= 1'b0;
      done <= 1'b0; frame <= '0;
    end else begin
      done <= fin && !init;
      if (fin) begin
        frame.data <= shreg;
        frame.frm  <= bad_stop | ~rxd;
        frame.par  <= perr_q;
      end
      if (init) begin
        state <= S_IDLE; os_cnt <= '0; line_q <= 1'b0;
      end else if (tick) begin
        case (state)
          S_IDLE: begin
            line_q <= rxd;
            os_cnt <= '0;
            if (line_q && !rxd) begin
              state <= S_START;
              two_q <= two_stop; pen_q <= par_en; odd_q <= par_odd;
            end
          end
          S_START: begin
            if (os_cnt == CW'(MID)) begin
              os_cnt <= '0;
              if (rxd) state <= S_IDLE;
              else begin
                state <= S_DATA; bit_idx <= '0;
                par_acc <= 1'b0; perr_q <= 1'b0; bad_stop <= 1'b0;
              end
            end else os_cnt <= os_cnt + 1'b1;
          end
          default: begin
            if (bit_end) begin
              os_cnt <= '0;
              case (state)
                S_DATA: begin
                  shreg   <= {rxd, shreg[7:1]};
                  par_acc <= par_acc ^ rxd;
                  bit_idx <= bit_idx + 1'b1;
                  if (bit_idx == 3'd7) state <= pen_q ? S_PAR : S_STOP1;
                end
                S_PAR: begin
                  perr_q <= (par_acc ^ rxd) != odd_q;
                  state  <= S_STOP1;
                end
                S_STOP1: begin
                  bad_stop <= bad_stop | ~rxd;
                  if (two_q) state <= S_STOP2;
                  else begin state <= S_IDLE; line_q <= rxd; end
                end
                default: begin state <= S_IDLE; line_q <= rxd; end
              endcase
            end else os_cnt <= os_cnt + 1'b1;
          end
        endcase
      end
    end
  end

  AST_INIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> state == S_IDLE); // R12
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       done,
  input  rx_frame_t  frame,
  input  logic       stat_rd,
  input  logic       data_ready,
  output logic [7:0] data_q,
  output logic       rbf,
  output logic       oer,
  output logic       fer,
  output logic       per
);
  logic      pend_q, apply, pop, err;
  rx_frame_t pend_fr, af;

  always_comb begin
    pop   = rbf && data_ready;
    apply = (done || pend_q) && !stat_rd;
    af    = done ? frame : pend_fr;
    err   = af.frm || af.par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; pend_fr <= '0; data_q <= '0;
      rbf <= 1'b0; oer <= 1'b0; fer <= 1'b0; per <= 1'b0;
    end else if (init) begin
      pend_q <= 1'b0;
      rbf <= 1'b0; oer <= 1'b0; fer <= 1'b0; per <= 1'b0;
    end else if (stat_rd) begin
      oer <= 1'b0; fer <= 1'b0; per <= 1'b0;
      if (done) begin pend_q <= 1'b1; pend_fr <= frame; end
      if (pop) rbf <= 1'b0;
    end else if (apply) begin
      pend_q <= 1'b0;
      data_q <= af.data;
      fer    <= fer | af.frm;
      per    <= per | af.par;
      oer    <= oer | (rbf && !pop) | fer | per;
      rbf    <= err ? (rbf && !pop) : 1'b1;
    end else if (pop) begin
      rbf <= 1'b0;
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !(oer || fer || per)); // R3
  AST_NO_RISE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !$rose(rbf)); // R8
  AST_ERR_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stat_rd && (frame.frm || frame.par) && !rbf) |=> !rbf); // R6
  AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !done && !pend_q) |=> !rbf); // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oer) |-> $past(rbf || fer || per)); // R1
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OS    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rxd,
  input  logic [7:0]       mode,
  input  logic             stat_rd,
  input  logic             rx_init,
  output logic             data_valid,
  input  logic             data_ready,
  output logic [7:0]       data_out,
  output logic             ovr_err,
  output logic             frm_err,
  output logic             par_err
);
  logic [1:0] sync_q;
  logic       tick, done;
  rx_frame_t  frame;
  logic       unused_mode;

  assign unused_mode = ^{mode[7:6], mode[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  rx_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  rx_frame_sampler #(.OS(OS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(sync_q[1]),
    .two_stop(mode[MODE_TWO_STOP]), .par_en(mode[MODE_PAR_EN]),
    .par_odd(mode[MODE_ODD]), .init(rx_init), .done(done), .frame(frame)
  );

  rx_status_flags u_flags (
    .clk(clk), .rst_n(rst_n), .init(rx_init), .done(done), .frame(frame),
    .stat_rd(stat_rd), .data_ready(data_ready), .data_q(data_out),
    .rbf(data_valid), .oer(ovr_err), .fer(frm_err), .per(par_err)
  );
endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] baud_div = 8'd3;
  logic       rxd = 1'b1;
  logic [7:0] mode = 8'h00;
  logic       stat_rd = 1'b0;
  logic       rx_init = 1'b0;
  logic       data_valid, data_ready = 1'b0;
  logic [7:0] data_out;
  logic       ovr_err, frm_err, par_err;
  int         errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rxd(rxd), .mode(mode),
    .stat_rd(stat_rd), .rx_init(rx_init), .data_valid(data_valid),
    .data_ready(data_ready), .data_out(data_out), .ovr_err(ovr_err),
    .frm_err(frm_err), .par_err(par_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return 16 * (int'(baud_div) + 1);
  endfunction

  task automatic line(input logic v, input int n);
    @(negedge clk) rxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pen, input logic odd,
                            input logic flip, input logic s1, input logic s2,
                            input logic two, input logic rd_last);
    logic p;
    p = (^d) ^ odd ^ flip;
    line(1'b0, bit_clks());
    for (int i = 0; i < 8; i++) line(d[i], bit_clks());
    if (pen) line(p, bit_clks());
    if (two) begin
      line(s1, bit_clks());
      @(negedge clk) rxd = s2; stat_rd = rd_last;
      repeat (bit_clks() - 1) @(negedge clk);
    end else begin
      @(negedge clk) rxd = s1; stat_rd = rd_last;
      repeat (bit_clks() - 1) @(negedge clk);
    end
    if (!rd_last) line(1'b1, bit_clks());
  endtask

  task automatic good(input logic [7:0] d);
    send_frame(d, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic pop();
    @(negedge clk) data_ready = 1'b1;
    @(negedge clk) data_ready = 1'b0;
  endtask

  task automatic sread();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 valid", data_valid, 0);
    chk("R13 flags", {ovr_err, frm_err, par_err}, 0);
  endtask

  task automatic t_basic();
    mode = 8'h00;
    good(8'hA5);
    chk("R6 valid", data_valid, 1);
    chk("R9 data", data_out, 8'hA5);
    chk("R6 flags", {ovr_err, frm_err, par_err}, 0);
    pop();
    chk("R7 popped", data_valid, 0);
  endtask

  task automatic t_overrun();
    good(8'h3C);
    good(8'hC3);
    chk("R1 ovr", ovr_err, 1);
    chk("R1 data", data_out, 8'hC3);
    sread();
    chk("R3 ovr cleared", ovr_err, 0);
    chk("R7 still valid", data_valid, 1);
    pop();
  endtask

  task automatic t_framing();
    send_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 fer", frm_err, 1);
    chk("R6 no valid on error", data_valid, 0);
    good(8'h0F);
    chk("R2 ovr from unread error", ovr_err, 1);
    chk("R2 fer kept", frm_err, 1);
    chk("R6 valid", data_valid, 1);
    chk("R9 data", data_out, 8'h0F);
    sread();
    chk("R3 cleared", {ovr_err, frm_err, par_err}, 0);
    pop();
  endtask

  task automatic t_two_stop();
    mode = 8'h08;
    send_frame(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    line(1'b1, bit_clks());
    chk("R4 second stop low", frm_err, 1);
    sread();
    send_frame(8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4 first stop low", frm_err, 1);
    chk("R4 no valid", data_valid, 0);
    sread();
    send_frame(8'hE7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R9 two stop data", data_out, 8'hE7);
    chk("R4 clean", {data_valid, frm_err}, 2'b10);
    pop();
    mode = 8'h00;
  endtask

  task automatic t_parity();
    mode = 8'h30;
    send_frame(8'h07, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5 odd ok", {data_valid, par_err}, 2'b10);
    chk("R5 data", data_out, 8'h07);
    pop();
    send_frame(8'h07, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5 odd bad", {data_valid, par_err}, 2'b01);
    sread();
    mode = 8'h20;
    send_frame(8'h6B, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5 even bad", par_err, 1);
    sread();
    send_frame(8'h6B, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5 even ok", {data_valid, par_err}, 2'b10);
    pop();
    mode = 8'h10;
    good(8'h01);
    chk("R5 disabled", {data_valid, par_err, data_out}, {2'b10, 8'h01});
    pop();
    mode = 8'h00;
  endtask

  task automatic t_read_defer();
    send_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 held during read", data_valid, 0);
    chk("R8 data unchanged", data_out, 8'h01);
    @(negedge clk) stat_rd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 applied after read", data_valid, 1);
    chk("R8 data", data_out, 8'h96);
    chk("R8 no overrun", ovr_err, 0);
    pop();
  endtask

  task automatic t_glitch();
    line(1'b0, 20);
    line(1'b1, 3 * bit_clks());
    chk("R10 no byte", data_valid, 0);
    chk("R10 no flags", {ovr_err, frm_err, par_err}, 0);
    good(8'h81);
    chk("R10 next frame", data_out, 8'h81);
    pop();
  endtask

  task automatic t_init();
    good(8'h44);
    send_frame(8'h45, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R12 precondition", {data_valid, ovr_err, frm_err}, 3'b111);
    @(negedge clk) rx_init = 1'b1;
    @(negedge clk) rx_init = 1'b0;
    chk("R12 cleared", {data_valid, ovr_err, frm_err, par_err}, 0);
    good(8'h2D);
    chk("R12 resumes", {data_valid, data_out}, {1'b1, 8'h2D});
    pop();
  endtask

  task automatic t_divider();
    baud_div = 8'd1;
    good(8'h5A);
    chk("R11 short bit", {data_valid, data_out}, {1'b1, 8'h5A});
    pop();
    baud_div = 8'd3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2 * bit_clks()) @(negedge clk);
    t_reset();
    t_basic();
    t_overrun();
    t_framing();
    t_two_stop();
    t_parity();
    t_read_defer();
    t_glitch();
    t_init();
    t_divider();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule